// File: doc/BRIEF.md
# Second-Level Interrupt Router with Bypass

This block collects 32 level-sensitive interrupt sources and presents them to the next controller up in two ways. Sources that are pending and enabled are merged onto a small set of parent interrupt lines. A per-parent routing mask chooses which sources feed each line, so one source may reach several parents or none at all. Selected sources can instead be marked for forwarding. A forwarded source skips the enable and routing logic and drives its own dedicated upstream line. This suits sources such as serial ports, which a system may wire either to a private line or to the shared output.

Software sees two 32-bit words on a simple register bus. The first is an enable word, which is only ever replaced whole, so setting or clearing a single bit takes a read-modify-write. The second is a read-only status word that mirrors the registered source levels. The routing masks and the forward mask are static configuration inputs from the surrounding chip.

Top module: `irq_l2_router`

## Requirements
- R1: After reset the enable word is all zeros, every parent line is low and the read data bus is zero.
- R2: A write at offset 0x0 replaces all 32 bits of the enable word, and a read of offset 0x0 returns that word on the cycle after the address is presented.
- R3: A read of offset 0x4 returns the source levels as sampled at the clock edge before the read, one bit per source, with bit i being source i.
- R4: A write at offset 0x4 has no effect: the status word still follows the sources and the enable word is unchanged.
- R5: Parent line p is high exactly when some source i has its registered status set, enable bit i set, bit i of routing mask p set, and forward bit i clear. Routing mask p occupies bits [p*32+31 : p*32] of the mask input.
- R6: Forward line i equals registered status bit i whenever forward bit i is set, whatever the enable word holds. It is low when forward bit i is clear.
- R7: A source with its forward bit set never raises any parent line, even when it is enabled and routed.
- R8: A read of any offset other than 0x0 or 0x4 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 32 | Level interrupt sources |
| route_mask | input | 64 | Per-parent routing masks, parent p in slice p |
| fwd_mask | input | 32 | Sources sent to dedicated lines |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read |
| parent_irq | output | 2 | Merged parent interrupt lines |
| fwd_irq | output | 32 | Dedicated forwarded lines |

## Verification
The assertions assume the sources and configuration inputs are known, two-state values at every clock edge. They also assume that a read and a write are not issued in the same cycle. The bench changes all inputs only on the falling edge and issues one bus operation at a time. It holds the routing and forward masks steady across each comparison window, so every expected value follows from a single set of inputs.

// File: rtl/irq_l2_pkg.sv
package irq_l2_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h4;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_lvl,
  output logic [N_SRC-1:0] status_q
);
  logic [N_SRC-1:0] status_d;

  always_comb begin
    status_d = src_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) || 1'b1 |=> status_q == $past(src_lvl)); // R3
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_l2_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [N_SRC-1:0]  reg_wdata,
  input  logic [N_SRC-1:0]  status_q,
  output logic [N_SRC-1:0]  enable_q,
  output logic [N_SRC-1:0]  reg_rdata
);
  logic             en_load;
  logic [N_SRC-1:0] enable_d;
  logic [N_SRC-1:0] rdata_d;
  logic [N_SRC-1:0] rdata_q;

  always_comb begin
    en_load  = reg_wr && (reg_addr == OFS_ENABLE);
    enable_d = en_load ? reg_wdata : enable_q;
    rdata_d  = rdata_q;
    if (reg_rd) begin
      unique case (reg_addr)
        OFS_ENABLE: rdata_d = enable_q;
        OFS_STATUS: rdata_d = status_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      rdata_q  <= '0;
    end else begin
      enable_q <= enable_d;
      rdata_q  <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_ENABLE) |=> enable_q == $past(reg_wdata)); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFS_ENABLE) |=> $stable(enable_q)); // R4
  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr != OFS_ENABLE && reg_addr != OFS_STATUS) |=> reg_rdata == '0); // R8
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned N_PARENT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          status_q,
  input  logic [N_SRC-1:0]          enable_q,
  input  logic [N_SRC-1:0]          fwd_mask,
  input  logic [N_PARENT*N_SRC-1:0] route_mask,
  output logic [N_PARENT-1:0]       parent_irq,
  output logic [N_SRC-1:0]          fwd_irq
);
  logic [N_SRC-1:0] pend;

  always_comb begin
    pend    = status_q & enable_q & ~fwd_mask;
    fwd_irq = status_q & fwd_mask;
  end

  for (genvar p = 0; p < N_PARENT; p++) begin : g_parent
    assign parent_irq[p] = |(pend & route_mask[p*N_SRC +: N_SRC]);
  end

  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> (parent_irq == '0)); // R1
  AST_FWD_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mask == '1) |-> (parent_irq == '0)); // R7
  AST_FWD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_irq & ~fwd_mask) == '0); // R6
endmodule

// File: rtl/irq_l2_router.sv
module irq_l2_router
  import irq_l2_pkg::*;
#(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned N_PARENT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          src_lvl,
  input  logic [N_PARENT*N_SRC-1:0] route_mask,
  input  logic [N_SRC-1:0]          fwd_mask,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [N_SRC-1:0]          reg_wdata,
  output logic [N_SRC-1:0]          reg_rdata,
  output logic [N_PARENT-1:0]       parent_irq,
  output logic [N_SRC-1:0]          fwd_irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_capture #(.N_SRC(N_SRC)) u_capture (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .src_lvl  (src_lvl),
    .status_q (status_q)
  );

  irq_regfile #(.N_SRC(N_SRC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .reg_rdata (reg_rdata)
  );

  irq_route #(.N_SRC(N_SRC), .N_PARENT(N_PARENT)) u_route (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .status_q   (status_q),
    .enable_q   (enable_q),
    .fwd_mask   (fwd_mask),
    .route_mask (route_mask),
    .parent_irq (parent_irq),
    .fwd_irq    (fwd_irq)
  );
endmodule

// File: tb/test_irq_l2_router.sv
module test_irq_l2_router;
  localparam int N = 32;
  localparam int P = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   src_lvl;
  logic [P*N-1:0] route_mask;
  logic [N-1:0]   fwd_mask;
  logic [3:0]     reg_addr;
  logic           reg_wr, reg_rd;
  logic [N-1:0]   reg_wdata;
  logic [N-1:0]   reg_rdata;
  logic [P-1:0]   parent_irq;
  logic [N-1:0]   fwd_irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [N-1:0] en_model;

  always #2 clk = ~clk;

  irq_l2_router i_irq_l2_router (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .route_mask(route_mask),
    .fwd_mask(fwd_mask), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .parent_irq(parent_irq),
    .fwd_irq(fwd_irq)
  );

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  function automatic logic [P-1:0] exp_parent(logic [N-1:0] s, logic [N-1:0] e,
                                              logic [N-1:0] f, logic [P*N-1:0] m);
    logic [P-1:0] r;
    for (int p = 0; p < P; p++) begin
      r[p] = 1'b0;
      for (int i = 0; i < N; i++)
        if (s[i] && e[i] && !f[i] && m[p*N+i]) r[p] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 4'h0) en_model = d;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle_src(logic [N-1:0] s);
    @(negedge clk);
    src_lvl = s;
    @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] rd;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; src_lvl = '0; route_mask = '0; fwd_mask = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0; en_model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 rdata", reg_rdata, 0);
    src_lvl = '1; route_mask = '1;
    @(negedge clk); @(negedge clk);
    check("R1 parent", parent_irq, 0);
    bus_read(4'h0, rd);
    check("R1 enable", rd, 0);

    // R2: enable write and readback
    bus_write(4'h0, 32'hA5A5_0F0F);
    bus_read(4'h0, rd);
    check("R2 enable readback", rd, 32'hA5A5_0F0F);

    // R3: status reflects sources
    settle_src(32'h1234_8001);
    bus_read(4'h4, rd);
    check("R3 status", rd, 32'h1234_8001);

    // R4: write to status ignored
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, rd);
    check("R4 status unchanged", rd, 32'h1234_8001);
    bus_read(4'h0, rd);
    check("R4 enable unchanged", rd, 32'hA5A5_0F0F);

    // R8: unmapped offsets
    bus_read(4'h8, rd);
    check("R8 offset 8", rd, 0);
    bus_read(4'hC, rd);
    check("R8 offset C", rd, 0);

    // R5: one source routed to parent 1 only
    bus_write(4'h0, 32'h0000_0010);
    route_mask = {32'h0000_0010, 32'h0000_0000};
    fwd_mask = '0;
    settle_src(32'h0000_0010);
    check("R5 single route", parent_irq, 2'b10);
    // R5: routed to both parents
    route_mask = {32'h0000_0010, 32'h0000_0010};
    @(negedge clk);
    check("R5 both routes", parent_irq, 2'b11);
    // R5: routed to neither
    route_mask = {32'hFFFF_FFEF, 32'hFFFF_FFEF};
    @(negedge clk);
    check("R5 no route", parent_irq, 2'b00);

    // R7: forwarded bit stays off parent lines
    route_mask = '1;
    fwd_mask = 32'h0000_0010;
    @(negedge clk);
    check("R7 forwarded excluded", parent_irq, 2'b00);
    // R6: forward line independent of enable
    bus_write(4'h0, 32'h0);
    settle_src(32'h8000_0011);
    fwd_mask = 32'h8000_0010;
    @(negedge clk);
    check("R6 forward lines", fwd_irq, 32'h8000_0010);

    // Random sweep over R3 R5 R6
    for (int k = 0; k < 300; k++) begin
      logic [N-1:0] s;
      s = $urandom;
      if (k % 4 == 0) bus_write(4'h0, $urandom);
      @(negedge clk);
      route_mask = {$urandom, $urandom};
      fwd_mask = $urandom & $urandom;
      settle_src(s);
      check("R5 random parent", parent_irq, exp_parent(s, en_model, fwd_mask, route_mask));
      check("R6 random forward", fwd_irq, s & fwd_mask);
      if (k % 8 == 0) begin
        bus_read(4'h4, rd);
        check("R3 random status", rd, s);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule